// File: doc/BRIEF.md
# Memory Error First/Next Logger

This block sits beside the ECC checker of a memory controller and records the error events that checker raises. Errors come in two classes, correctable and uncorrectable. For each class the block keeps a first-error status bit and a next-error status bit. The first event of a class records its location: the 4 KiB block number of the address, plus the syndrome for the correctable class. Any later event of that class only marks the next-error bit, so the recorded location always points at the earliest error that has not yet been acknowledged.

Software reads the status and log registers through a simple register port. It acknowledges errors by writing ones to the status bits. The block also guesses which memory channel the logged correctable error came from, based on the shape of the logged syndrome.

Each class is tracked by a small four-state machine. The states are:

- `CLS_CLEAN`: no bits set.
- `CLS_FIRST`: only the first bit is set.
- `CLS_NEXT_ONLY`: only the next bit is set, because the first bit was acknowledged.
- `CLS_BOTH`: both bits are set.

The transitions are:

- **capture**: an event in `CLS_CLEAN` or `CLS_NEXT_ONLY` goes to `CLS_FIRST` or `CLS_BOTH` respectively, and records the location.
- **overflow**: an event in `CLS_FIRST` or `CLS_BOTH` goes to `CLS_BOTH` without recording.
- **acknowledge**: with no event present, a write-1 clears either bit and moves to the state that matches the bits that remain.
- **hold**: any other cycle leaves the state unchanged.

Top module: `mem_err_logger`

## Requirements
- R1: After reset, every readable offset (0 to 5) returns zero, and `chan_guess` is 0.
- R2: Offset 0 is the first-error status and offset 1 is the next-error status. In both, bit 0 is the correctable class and bit 1 is the uncorrectable class. Bits 31:2 always read zero.
- R3: An event of a class whose first-error bit is clear sets that bit one cycle later. It also captures the address; a correctable event additionally captures the syndrome.
- R4: An event of a class whose first-error bit is already set sets that class's next-error bit. The logged address and syndrome stay unchanged.
- R5: Writing 1 to bit 0 or bit 1 of offset 0 or offset 1 clears that bit. Writing 0 leaves it unchanged.
- R6: An event arriving in the same cycle as a clear of its class wins. The class's first-error bit ends up set, and the next-error bit is set if the first-error bit was already set.
- R7: Once a class's first-error bit has been cleared, its next event is captured as a first error again, even while its next-error bit is still set.
- R8: Offset 2 holds the correctable log address and offset 4 holds the uncorrectable log address. In each, bits 27:6 equal address bits 33:12 and all other bits read zero. Offset 3 bits 15:0 hold the correctable syndrome.
- R9: The channel guess is computed from the logged syndrome and is readable at offset 5 bits 1:0 and on `chan_guess`. The checks are made in this order:
  - syndrome bits 15:8 all zero gives 0;
  - otherwise, bits 7:0 all zero gives 1;
  - otherwise, bits 15:12 zero or bits 11:8 zero gives 0;
  - otherwise the result is 3, meaning unknown.
- R10: Events and clears of one class leave the other class's status bits and log unchanged.
- R11: Writes to offsets 2 to 5 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error event from the ECC checker |
| ue_evt | input | 1 | Uncorrectable error event from the ECC checker |
| err_addr | input | PA_W (34) | Physical address of the failing access |
| err_syn | input | SYN_W (16) | Syndrome of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| chan_guess | output | 2 | Channel guess for the logged correctable syndrome |

## Verification
The bench builds the block with its default parameters: a 34-bit address, a 12-bit page shift and a 16-bit syndrome. With these values the block number fills log bits 27:6 completely, so addresses with bit 33 set show whether the top of the field is placed correctly. The 16-bit syndrome also makes all four channel-decode outcomes reachable with hand-picked patterns.

// File: rtl/mel_pkg.sv
package mel_pkg;
    typedef enum logic [1:0] {
        CLS_CLEAN     = 2'd0,
        CLS_FIRST     = 2'd1,
        CLS_NEXT_ONLY = 2'd2,
        CLS_BOTH      = 2'd3
    } cls_state_e;

    localparam int NUM_CLASSES = 2;
    localparam int CLS_CE      = 0;
    localparam int CLS_UE      = 1;

    localparam logic [2:0] OFS_FIRST  = 3'd0;
    localparam logic [2:0] OFS_NEXT   = 3'd1;
    localparam logic [2:0] OFS_CEADDR = 3'd2;
    localparam logic [2:0] OFS_CESYN  = 3'd3;
    localparam logic [2:0] OFS_UEADDR = 3'd4;
    localparam logic [2:0] OFS_CHAN   = 3'd5;

    localparam logic [1:0] CHAN_UNKNOWN = 2'd3;
endpackage

// File: rtl/err_class_fsm.sv
module err_class_fsm
    import mel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_first,
    input  logic clr_next,
    output logic first_o,
    output logic next_o,
    output logic capture_o
);
    cls_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLS_CLEAN: begin
                if (evt) state_d = CLS_FIRST;
            end
            CLS_FIRST: begin
                if (evt)            state_d = CLS_BOTH;
                else if (clr_first) state_d = CLS_CLEAN;
            end
            CLS_NEXT_ONLY: begin
                if (evt)           state_d = CLS_BOTH;
                else if (clr_next) state_d = CLS_CLEAN;
            end
            CLS_BOTH: begin
                if (evt)                        state_d = CLS_BOTH;
                else if (clr_first && clr_next) state_d = CLS_CLEAN;
                else if (clr_first)             state_d = CLS_NEXT_ONLY;
                else if (clr_next)              state_d = CLS_FIRST;
            end
            default: state_d = CLS_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLS_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        first_o   = 1'b0;
        next_o    = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            CLS_CLEAN:     capture_o = evt;
            CLS_FIRST:     first_o   = 1'b1;
            CLS_NEXT_ONLY: begin
                next_o    = 1'b1;
                capture_o = evt;
            end
            CLS_BOTH: begin
                first_o = 1'b1;
                next_o  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/syn_chan_decode.sv
module syn_chan_decode
    import mel_pkg::*;
#(
    parameter int SYN_W = 16
) (
    input  logic [SYN_W-1:0] syn,
    output logic [1:0]       chan
);
    localparam int HALF = SYN_W / 2;

    logic hi_zero, lo_zero, nib_zero;

    assign hi_zero  = (syn[SYN_W-1:HALF] == '0);
    assign lo_zero  = (syn[HALF-1:0] == '0);
    assign nib_zero = (syn[SYN_W-1 -: 4] == 4'd0) || (syn[SYN_W-5 -: 4] == 4'd0);

    always_comb begin
        if (hi_zero)       chan = 2'd0;
        else if (lo_zero)  chan = 2'd1;
        else if (nib_zero) chan = 2'd0;
        else               chan = CHAN_UNKNOWN;
    end
endmodule

// File: rtl/err_log_regs.sv
module err_log_regs
    import mel_pkg::*;
#(
    parameter int BLK_W  = 22,
    parameter int SYN_W  = 16,
    parameter int DATA_W = 32,
    parameter int LOG_LSB = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLASSES-1:0] capture,
    input  logic [BLK_W-1:0]       blk_in,
    input  logic [SYN_W-1:0]       syn_in,
    input  logic [NUM_CLASSES-1:0] st_first,
    input  logic [NUM_CLASSES-1:0] st_next,
    input  logic [1:0]             chan,
    input  logic [2:0]             rd_addr,
    output logic [BLK_W-1:0]       ce_blk,
    output logic [SYN_W-1:0]       ce_syn,
    output logic [BLK_W-1:0]       ue_blk,
    output logic [DATA_W-1:0]      rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_blk <= '0;
            ce_syn <= '0;
            ue_blk <= '0;
        end else begin
            if (capture[CLS_CE]) begin
                ce_blk <= blk_in;
                ce_syn <= syn_in;
            end
            if (capture[CLS_UE]) ue_blk <= blk_in;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rd_addr)
            OFS_FIRST:  rdata[NUM_CLASSES-1:0]         = st_first;
            OFS_NEXT:   rdata[NUM_CLASSES-1:0]         = st_next;
            OFS_CEADDR: rdata[LOG_LSB+BLK_W-1:LOG_LSB] = ce_blk;
            OFS_CESYN:  rdata[SYN_W-1:0]               = ce_syn;
            OFS_UEADDR: rdata[LOG_LSB+BLK_W-1:LOG_LSB] = ue_blk;
            OFS_CHAN:   rdata[1:0]                     = chan;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
    import mel_pkg::*;
#(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 12,
    parameter int LOG_LSB    = 6,
    parameter int SYN_W      = 16,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic [PA_W-1:0]   err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        chan_guess
);
    localparam int BLK_W = PA_W - PAGE_SHIFT;

    logic [NUM_CLASSES-1:0] evt_vec, clr_first, clr_next;
    logic [NUM_CLASSES-1:0] st_first, st_next, capture;
    logic [BLK_W-1:0]       ce_blk, ue_blk;
    logic [SYN_W-1:0]       ce_syn;

    assign evt_vec[CLS_CE] = ce_evt;
    assign evt_vec[CLS_UE] = ue_evt;

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
        assign clr_first[k] = reg_wr && (reg_addr == OFS_FIRST) && reg_wdata[k];
        assign clr_next[k]  = reg_wr && (reg_addr == OFS_NEXT)  && reg_wdata[k];

        err_class_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_vec[k]),
            .clr_first (clr_first[k]),
            .clr_next  (clr_next[k]),
            .first_o   (st_first[k]),
            .next_o    (st_next[k]),
            .capture_o (capture[k])
        );
    end

    syn_chan_decode #(.SYN_W(SYN_W)) u_dec (
        .syn  (ce_syn),
        .chan (chan_guess)
    );

    err_log_regs #(
        .BLK_W   (BLK_W),
        .SYN_W   (SYN_W),
        .DATA_W  (DATA_W),
        .LOG_LSB (LOG_LSB)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .blk_in   (err_addr[PA_W-1:PAGE_SHIFT]),
        .syn_in   (err_syn),
        .st_first (st_first),
        .st_next  (st_next),
        .chan     (chan_guess),
        .rd_addr  (reg_addr),
        .ce_blk   (ce_blk),
        .ce_syn   (ce_syn),
        .ue_blk   (ue_blk),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/mel_checker.sv
module mel_checker #(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 12,
    parameter int SYN_W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ce_evt,
    input logic                   ue_evt,
    input logic [PA_W-1:0]        err_addr,
    input logic [SYN_W-1:0]       err_syn,
    input logic [1:0]             st_first,
    input logic [1:0]             st_next,
    input logic [PA_W-PAGE_SHIFT-1:0] ce_blk,
    input logic [SYN_W-1:0]       ce_syn,
    input logic [PA_W-PAGE_SHIFT-1:0] ue_blk,
    input logic [1:0]             chan_guess
);
    AST_CE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt && !st_first[0] |=> ce_blk == $past(err_addr[PA_W-1:PAGE_SHIFT]) && ce_syn == $past(err_syn)); // R3
    AST_UE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ue_evt && !st_first[1] |=> ue_blk == $past(err_addr[PA_W-1:PAGE_SHIFT])); // R3
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt && st_first[0] |=> $stable(ce_blk) && $stable(ce_syn) && st_next[0]); // R4
    AST_UE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ue_evt && st_first[1] |=> $stable(ue_blk) && st_next[1]); // R4
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> st_first[0]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_first[1]) |-> $past(ue_evt)); // R10
    AST_CHAN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ce_syn[SYN_W-1:SYN_W/2] == '0 |-> chan_guess == 2'd0); // R9
endmodule

bind mem_err_logger mel_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_evt     (ce_evt),
    .ue_evt     (ue_evt),
    .err_addr   (err_addr),
    .err_syn    (err_syn),
    .st_first   (st_first),
    .st_next    (st_next),
    .ce_blk     (ce_blk),
    .ce_syn     (ce_syn),
    .ue_blk     (ue_blk),
    .chan_guess (chan_guess)
);

// File: tb/mem_err_logger_test.sv
`timescale 1ns/1ps
module mem_err_logger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 1'b0, ue_evt = 1'b0;
    logic [33:0] err_addr = '0;
    logic [15:0] err_syn = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  chan_guess;

    logic        rd_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    mem_err_logger uut (.*);

    function automatic logic [31:0] blk_field(input logic [33:0] a);
        return {4'b0, a[33:12], 6'b0};
    endfunction

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = a; port_sel = 0; rd_en = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic expect_port(input logic [1:0] e, input string t);
        @(negedge clk);
        port_sel = 1; rd_en = 1;
        exp_q.push_back({30'b0, e}); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 0; port_sel = 0;
    endtask

    task automatic fire(input logic c, input logic u, input logic [33:0] a, input logic [15:0] s,
                        input logic w, input logic [2:0] wa, input logic [31:0] wd);
        @(negedge clk);
        ce_evt = c; ue_evt = u; err_addr = a; err_syn = s;
        reg_wr = w; reg_addr = wa; reg_wdata = wd;
        @(negedge clk);
        ce_evt = 0; ue_evt = 0; reg_wr = 0;
    endtask

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rd_en) begin
                logic [31:0] act, e;
                string t;
                act = port_sel ? {30'b0, chan_guess} : reg_rdata;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (act !== e) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    localparam logic [33:0] A1 = 34'h2_3456_7ABC;
    localparam logic [33:0] A2 = 34'h1_ABCD_E123;
    localparam logic [33:0] A3 = 34'h3_F00F_1FFF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int i = 0; i < 6; i++) expect_rd(i[2:0], 32'h0, "R1 reset read");
        expect_port(2'd0, "R1 reset chan");

        // R3 / R8 first correctable capture
        fire(1, 0, A1, 16'h00C3, 0, 3'd0, 0);
        expect_rd(3'd0, 32'h1, "R3 first CE bit");
        expect_rd(3'd1, 32'h0, "R2 next clear");
        expect_rd(3'd2, blk_field(A1), "R8 CE addr");
        expect_rd(3'd3, 32'h0000_00C3, "R8 CE syndrome");
        expect_rd(3'd5, 32'h0, "R9 upper byte zero");
        expect_rd(3'd4, 32'h0, "R10 UE log untouched");

        // R4 second CE keeps log
        fire(1, 0, A2, 16'h5A00, 0, 3'd0, 0);
        expect_rd(3'd1, 32'h1, "R4 next CE bit");
        expect_rd(3'd2, blk_field(A1), "R4 CE addr kept");
        expect_rd(3'd3, 32'h0000_00C3, "R4 syndrome kept");

        // R5 write 0 no effect, R11 log writes ignored
        fire(0, 0, '0, '0, 1, 3'd0, 32'h0);
        expect_rd(3'd0, 32'h1, "R5 write zero keeps");
        fire(0, 0, '0, '0, 1, 3'd2, 32'hFFFF_FFFF);
        fire(0, 0, '0, '0, 1, 3'd3, 32'hFFFF_FFFF);
        expect_rd(3'd2, blk_field(A1), "R11 CE addr write ignored");
        expect_rd(3'd3, 32'h0000_00C3, "R11 syndrome write ignored");

        // R3 first UE
        fire(0, 1, A3, 16'hFFFF, 0, 3'd0, 0);
        expect_rd(3'd0, 32'h3, "R3 first UE bit");
        expect_rd(3'd4, blk_field(A3), "R8 UE addr");
        expect_rd(3'd1, 32'h1, "R10 UE leaves CE next");
        expect_rd(3'd3, 32'h0000_00C3, "R10 UE leaves CE syndrome");

        // R5 clear CE first bit only
        fire(0, 0, '0, '0, 1, 3'd0, 32'h1);
        expect_rd(3'd0, 32'h2, "R5 clear CE first");

        // R7 recapture while next bit still set
        fire(1, 0, A2, 16'h5A00, 0, 3'd0, 0);
        expect_rd(3'd0, 32'h3, "R7 CE first again");
        expect_rd(3'd2, blk_field(A2), "R7 CE addr recaptured");
        expect_rd(3'd3, 32'h0000_5A00, "R7 syndrome recaptured");
        expect_rd(3'd5, 32'h1, "R9 lower byte zero");
        expect_port(2'd1, "R9 chan port");

        // R5 / R2 clear next with extra bits
        fire(0, 0, '0, '0, 1, 3'd1, 32'hFFFF_FFFF);
        expect_rd(3'd1, 32'h0, "R5 next cleared");

        // R6 UE event with simultaneous clear of UE first bit
        fire(0, 1, A1, 16'h0, 1, 3'd0, 32'h2);
        expect_rd(3'd0, 32'h3, "R6 event wins");
        expect_rd(3'd1, 32'h2, "R6 next UE set");
        expect_rd(3'd4, blk_field(A3), "R6 UE log kept");

        // R9 nibble rule and unknown
        fire(0, 0, '0, '0, 1, 3'd0, 32'h3);
        expect_rd(3'd0, 32'h0, "R5 both first cleared");
        fire(1, 0, A3, 16'h0C5A, 0, 3'd0, 0);
        expect_rd(3'd5, 32'h0, "R9 top nibble zero");
        fire(0, 0, '0, '0, 1, 3'd0, 32'h1);
        fire(1, 0, A1, 16'h3C5A, 0, 3'd0, 0);
        expect_rd(3'd5, 32'h3, "R9 unknown");
        expect_port(2'd3, "R9 unknown port");
        expect_rd(3'd2, blk_field(A1), "R8 CE addr high bit");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule